// File: doc/BRIEF.md
# Strobed Input Port Handshake

This block is a latched byte-wide input port that a peripheral fills by pulsing an active-low load strobe. A falling strobe raises an input-buffer-full flag toward the host, and the byte on the peripheral bus is captured for as long as the strobe stays low. Once the strobe has returned high with the buffer full and the port's interrupt enable set, an interrupt request goes to the host. A host read of the port drops the interrupt at the start of the read, and drops the buffer-full flag when the read ends.

The peripheral strobe and the host read strobe are asynchronous to the block clock. Both are synchronized and turned into one-cycle edge events. The peripheral data goes through a matching delay so that it stays aligned with the strobe. The interrupt enable is a single bit owned by this port. A single-bit command from the host sets or clears it when the command's 3-bit bit index matches the index given to this instance, and a mode-selection pulse clears it. Host address decoding and output-direction handshakes live elsewhere.

Top module: `strobed_in_port`

## Requirements
- R1: After synchronous reset, the latched data is 0x00, and the buffer-full flag, the interrupt request and the interrupt enable are all 0.
- R2: The latched data follows the peripheral data while the strobe is low and freezes at the strobe's rising edge. Later changes on the peripheral bus leave it unchanged.
- R3: A falling strobe sets the buffer-full flag within a few clock cycles, while the strobe is still low. The interrupt request stays 0 while the strobe is low.
- R4: When the strobe is high, the buffer is full, the enable is 1 and no read is in progress, the interrupt request rises.
- R5: With the enable at 0, a completed strobe sets the buffer-full flag but never raises the interrupt request.
- R6: The falling edge of the host read strobe clears the interrupt request while the buffer-full flag stays 1 until the read ends.
- R7: The rising edge of the host read strobe clears the buffer-full flag.
- R8: A second strobe while the buffer is still full overwrites the latched data and leaves the flag at 1.
- R9: A command writes the enable only when its 3-bit bit index equals the instance parameter IE_BIT (default 4). cmd_set=1 sets the enable and cmd_set=0 clears it. A command with any other index is ignored.
- R10: Clearing the enable, by command or by a mode-selection pulse, drops a pending interrupt request on the next cycle.
- R11: Setting the enable while the buffer is full and the strobe is high raises the interrupt request.
- R12: When a read end and a strobe fall arrive in the same synchronized cycle, the clear wins and the buffer-full flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_data | input | DATA_W | Peripheral data bus |
| stb_n | input | 1 | Peripheral load strobe, active low, asynchronous |
| rd_n | input | 1 | Host read strobe for this port, active low, asynchronous |
| cmd_wr | input | 1 | One-cycle single-bit command valid |
| cmd_sel | input | SEL_W | Bit index addressed by the command |
| cmd_set | input | 1 | 1 sets, 0 clears the addressed bit |
| mode_load | input | 1 | One-cycle mode-selection pulse, clears the enable |
| port_data | output | DATA_W | Latched input byte |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request to the host |

## Verification
The main function is tried with several patterns. A single strobe followed by a read separates when the interrupt rises and falls from when the flag rises and falls. Back-to-back strobes with no read between them show that the data is overwritten while the flag holds. Enable commands that hit or miss this port's index are given with the buffer already full and the strobe high, so the interrupt output shows the hidden enable. A read end given in the same cycle as a new strobe fall shows which event has priority.

// File: rtl/strobe_in_pkg.sv
// Shared types for the strobed input port.
// Assumes: nothing beyond IEEE 1800-2017.
package strobe_in_pkg;

    // Synchronized level of an asynchronous strobe plus one-cycle edge events
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_evt_t;

endpackage

// File: rtl/edge_sync.sv
// Synchronizer and edge detector for one asynchronous control input.
// Assumes: STAGES >= 1. RST_VAL is the idle level of the input.
// Produces the synchronized level and one-cycle rise and fall pulses.
module edge_sync
    import strobe_in_pkg::*;
#(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      async_in,
    output edge_evt_t evt
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // First stage captures the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= async_in;
    end

    // Remaining stages form the metastability chain
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
        end
    end

    // Hold the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= chain[STAGES-1];
    end

    // Derive level and edge events
    always_comb begin
        evt.level = chain[STAGES-1];
        evt.rise  = chain[STAGES-1] & ~prev;
        evt.fall  = ~chain[STAGES-1] & prev;
    end

endmodule

// File: rtl/ie_ctrl.sv
// Interrupt-enable bit for one input port.
// Assumes: cmd_wr and mode_load are one-cycle pulses that are already
// synchronous. The enable answers only to commands whose index equals IE_BIT.
module ie_ctrl #(
    parameter int SEL_W  = 3,
    parameter int IE_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [SEL_W-1:0] cmd_sel,
    input  logic             cmd_set,
    input  logic             mode_load,
    output logic             inte
);

    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IE_BIT);

    // Mode selection clears the enable, otherwise a matching command writes it
    always_ff @(posedge clk) begin
        if (!rst_n)                            inte <= 1'b0;
        else if (mode_load)                    inte <= 1'b0;
        else if (cmd_wr && cmd_sel == MY_SEL)  inte <= cmd_set;
    end

    // R10
    mode_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> !inte);

    // R9
    foreign_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_sel != MY_SEL && !mode_load) |=> $stable(inte));

endmodule

// File: rtl/hs_flags.sv
// Data latch, buffer-full flag and interrupt request of the input handshake.
// Assumes: strobe and read events come from edge_sync. data_in has the same
// delay as the strobe. A clear event wins over a set event in the same cycle.
module hs_flags
    import strobe_in_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  edge_evt_t         stb,
    input  edge_evt_t         rd,
    input  logic [DATA_W-1:0] data_in,
    input  logic              inte,
    output logic [DATA_W-1:0] data_q,
    output logic              ibf,
    output logic              intr
);

    logic intr_set;

    // Latch follows data while strobe is low and closes on its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)                    data_q <= '0;
        else if (!stb.level || stb.rise) data_q <= data_in;
    end

    // Buffer full: read end clears, strobe fall sets, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n)        ibf <= 1'b0;
        else if (rd.rise)  ibf <= 1'b0;
        else if (stb.fall) ibf <= 1'b1;
    end

    // Interrupt set condition: strobe high, full, enabled, host not reading
    assign intr_set = stb.level & ibf & inte & rd.level & ~rd.rise;

    // Interrupt: read start clears, set condition raises, enable gates holding
    always_ff @(posedge clk) begin
        if (!rst_n)        intr <= 1'b0;
        else if (rd.fall)  intr <= 1'b0;
        else if (intr_set) intr <= 1'b1;
        else               intr <= intr & inte;
    end

    // R3
    ibf_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(stb.fall));

    // R7
    read_end_clears_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd.rise |=> !ibf);

    // R6
    read_start_clears_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd.fall |=> !intr);

    // R5
    intr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr) |-> ($past(inte) && $past(ibf)));

    // R8
    overwrite_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.fall && ibf && !rd.rise) |=> ibf);

endmodule

// File: rtl/strobed_in_port.sv
// Top of the strobed input port: synchronizes the peripheral strobe and the
// host read strobe, delays the peripheral data to match, and drives the latch,
// buffer-full and interrupt logic.
// Assumes: peripheral data is stable while the strobe is low. With
// ALIGN_DATA = 0 it must also stay stable for STAGES+1 cycles after the strobe rises.
module strobed_in_port
    import strobe_in_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int STAGES     = 2,
    parameter int SEL_W      = 3,
    parameter int IE_BIT     = 4,
    parameter bit ALIGN_DATA = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] periph_data,
    input  logic              stb_n,
    input  logic              rd_n,
    input  logic              cmd_wr,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic              cmd_set,
    input  logic              mode_load,
    output logic [DATA_W-1:0] port_data,
    output logic              ibf,
    output logic              intr
);

    edge_evt_t         stb_evt;
    edge_evt_t         rd_evt;
    logic              inte;
    logic [DATA_W-1:0] data_aligned;

    edge_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) i_stb_sync (
        .clk(clk), .rst_n(rst_n), .async_in(stb_n), .evt(stb_evt)
    );

    edge_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) i_rd_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rd_n), .evt(rd_evt)
    );

    if (ALIGN_DATA) begin : g_align
        logic [DATA_W-1:0] dpipe [STAGES];

        // Delay the data by the strobe synchronizer depth
        always_ff @(posedge clk) begin
            if (!rst_n) dpipe[0] <= '0;
            else        dpipe[0] <= periph_data;
        end

        for (genvar i = 1; i < STAGES; i++) begin : g_dstage
            // Further stages of the data delay
            always_ff @(posedge clk) begin
                if (!rst_n) dpipe[i] <= '0;
                else        dpipe[i] <= dpipe[i-1];
            end
        end

        assign data_aligned = dpipe[STAGES-1];
    end else begin : g_direct
        assign data_aligned = periph_data;
    end

    ie_ctrl #(.SEL_W(SEL_W), .IE_BIT(IE_BIT)) i_ie (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
        .cmd_set(cmd_set), .mode_load(mode_load), .inte(inte)
    );

    hs_flags #(.DATA_W(DATA_W)) i_flags (
        .clk(clk), .rst_n(rst_n), .stb(stb_evt), .rd(rd_evt),
        .data_in(data_aligned), .inte(inte),
        .data_q(port_data), .ibf(ibf), .intr(intr)
    );

    // R10
    enable_drop_clears_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr && !inte) |=> !intr);

    // R4
    intr_only_strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr) |-> $past(stb_evt.level));

endmodule

// File: tb/test_strobed_in_port.sv
module test_strobed_in_port;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int SETTLE     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] periph_data = '0;
    logic          stb_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          cmd_wr = 1'b0;
    logic [2:0]    cmd_sel = '0;
    logic          cmd_set = 1'b0;
    logic          mode_load = 1'b0;
    logic [DW-1:0] port_data;
    logic          ibf;
    logic          intr;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic          ibf;
        logic          intr;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;
    logic done = 1'b0;

    strobed_in_port i_strobed_in_port (
        .clk(clk), .rst_n(rst_n), .periph_data(periph_data), .stb_n(stb_n),
        .rd_n(rd_n), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel), .cmd_set(cmd_set),
        .mode_load(mode_load), .port_data(port_data), .ibf(ibf), .intr(intr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pop expected items and compare against outputs
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (ibf !== e.ibf || intr !== e.intr || port_data !== e.data) begin
                    errors++;
                    $display("FAIL %s: got ibf=%0b intr=%0b data=%02h, expected ibf=%0b intr=%0b data=%02h",
                             e.req, ibf, intr, port_data, e.ibf, e.intr, e.data);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: push expectation, then let the monitor sample at a negedge
    task automatic expect_now(input logic e_ibf, input logic e_intr,
                              input logic [DW-1:0] e_data, input string req);
        exp_t e;
        e.ibf = e_ibf; e.intr = e_intr; e.data = e_data; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        -> sample_ev;
        #1;
    endtask

    task automatic command(input logic [2:0] sel, input logic set);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_sel = sel; cmd_set = set;
        @(negedge clk);
        cmd_wr = 1'b0;
        idle(SETTLE);
    endtask

    task automatic strobe_low(input logic [DW-1:0] d);
        @(negedge clk);
        periph_data = d; stb_n = 1'b0;
        idle(SETTLE);
    endtask

    task automatic strobe_high();
        @(negedge clk);
        stb_n = 1'b1;
        idle(SETTLE);
    endtask

    task automatic set_rd(input logic v);
        @(negedge clk);
        rd_n = v;
        idle(SETTLE);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        expect_now(1'b0, 1'b0, 8'h00, "R1 reset state");

        command(3'd4, 1'b1);
        strobe_low(8'hA5);
        expect_now(1'b1, 1'b0, 8'hA5, "R3 full while strobe low");
        strobe_high();
        @(negedge clk); periph_data = 8'h3C;
        idle(SETTLE);
        expect_now(1'b1, 1'b1, 8'hA5, "R4 interrupt after strobe high, R2 latch frozen");

        set_rd(1'b0);
        expect_now(1'b1, 1'b0, 8'hA5, "R6 read start clears interrupt only");
        set_rd(1'b1);
        expect_now(1'b0, 1'b0, 8'hA5, "R7 read end clears full");

        strobe_low(8'h5A);
        strobe_high();
        expect_now(1'b1, 1'b1, 8'h5A, "R2 first strobe data");
        strobe_low(8'hC3);
        strobe_high();
        expect_now(1'b1, 1'b1, 8'hC3, "R8 overwrite while full");

        command(3'd4, 1'b0);
        expect_now(1'b1, 1'b0, 8'hC3, "R10 clear enable drops interrupt");
        command(3'd2, 1'b1);
        expect_now(1'b1, 1'b0, 8'hC3, "R9 foreign index ignored");
        command(3'd4, 1'b1);
        expect_now(1'b1, 1'b1, 8'hC3, "R11 R9 enabling raises interrupt");

        @(negedge clk); mode_load = 1'b1;
        @(negedge clk); mode_load = 1'b0;
        idle(SETTLE);
        expect_now(1'b1, 1'b0, 8'hC3, "R10 mode select drops interrupt");
        command(3'd5, 1'b1);
        expect_now(1'b1, 1'b0, 8'hC3, "R9 index 5 ignored");

        set_rd(1'b0);
        set_rd(1'b1);
        expect_now(1'b0, 1'b0, 8'hC3, "R7 full cleared again");

        strobe_low(8'h11);
        strobe_high();
        expect_now(1'b1, 1'b0, 8'h11, "R5 disabled strobe no interrupt");

        command(3'd4, 1'b1);
        expect_now(1'b1, 1'b1, 8'h11, "R11 late enable raises interrupt");
        set_rd(1'b0);
        @(negedge clk);
        rd_n = 1'b1; stb_n = 1'b0; periph_data = 8'h77;
        idle(SETTLE);
        expect_now(1'b0, 1'b0, 8'h77, "R12 clear wins over set");
        strobe_high();
        expect_now(1'b0, 1'b0, 8'h77, "R12 no interrupt without full");

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        expect_now(1'b0, 1'b0, 8'h00, "R1 second reset");

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule